// File: doc/BRIEF.md
# Eight-Line GPIO Port with Interrupt Merge

This block gives software on a 16-bit local bus control of eight general-purpose I/O lines that share one chip-select region. Each line is set to drive or to listen through a direction register. A separate data register holds the value presented to the pad. The synchronized pad levels can be read back at any time. The block drives the pad control pair for each line (output enable and output value) and samples the pad levels through a two-stage synchronizer.

Lines configured to listen can also act as interrupt sources. A single global merge bit, held in a miscellaneous-control register, decides whether listening lines reach the interrupt status register at all. Each status bit is level-sensitive. A per-line mask register gates the status bits, and one interrupt output is raised while any unmasked status bit is set.

On the bus every register bit sits in reversed significance: register bit n travels on data bit 15−n, so line 0 uses data bit 15 and line 7 uses data bit 8. Data bits 7..0 carry nothing.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction, output data, merge-enable and mask registers are all zero, so padOe, padOut and gpioIrq are all 0.
- R2: A write at byte offset 0x5C loads the direction register, where 1 means output and 0 means input, and padOe bit n follows direction bit n from the clock edge of the write onward. padOe changes only on such a write.
- R3: A write at offset 0x60 loads the output data register, and padOut bit n equals output data bit n whatever the direction of that line.
- R4: Register bit n is written from, and read back on, bus data bit 15−n for every register.
- R5: Bus data bits 7..0 always read as zero, and the values written on them have no effect.
- R6: Offset 0x64 reads the pad levels after a two-flop synchronizer: a pad change is not visible after the first rising edge and is visible after the second.
- R7: Offset 0x70 reads the interrupt status, where bit n = synchronized pad n AND direction bit n is 0 AND merge enable. Writes to this offset have no effect.
- R8: The merge enable is register bit 0 (bus bit 15) of the control register at offset 0x68. While it is 0 every status bit reads 0 and gpioIrq is 0.
- R9: The mask register sits at offset 0x6C, with 1 meaning enabled, and gpioIrq is the OR over n of status bit n AND mask bit n.
- R10: busRdata is zero when busCs is low, during a write, or at an offset not listed here, and a write with busCs low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busCs | input | 1 | Chip select for the register region |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset within the region |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from the address |
| padIn | input | 8 | Sampled pad levels, asynchronous |
| padOe | output | 8 | Pad output enables |
| padOut | output | 8 | Pad output values |
| gpioIrq | output | 1 | Interrupt request, level |

## Verification
The bench writes asymmetric patterns such as a single bit at either end of the byte. A design that forgot the lane reversal, or that took data from bits 7..0, would drive the wrong pad or change nothing. It samples the readback after one edge and after two, so a design with one synchronizer stage too many or too few would show the new level in the wrong cycle. It turns each gate in the interrupt path off one at a time (merge bit cleared, line turned to output, mask bit on a quiet line) and confirms that status and gpioIrq drop. A design missing any term of the AND would keep raising the interrupt. Writes to the status offset, writes with the chip select low, and reads of unmapped offsets must leave every observable value untouched.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_DIR,
    RD_OUT,
    RD_IN,
    RD_CTRL,
    RD_MASK,
    RD_STAT
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrOut;
    logic   wrCtrl;
    logic   wrMask;
    rdSel_e rdSel;
  } gpioStrobe_t;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFS_DIR  = 8'h5C,
  parameter logic [ADDR_W-1:0] OFFS_OUT  = 8'h60,
  parameter logic [ADDR_W-1:0] OFFS_IN   = 8'h64,
  parameter logic [ADDR_W-1:0] OFFS_CTRL = 8'h68,
  parameter logic [ADDR_W-1:0] OFFS_MASK = 8'h6C,
  parameter logic [ADDR_W-1:0] OFFS_STAT = 8'h70
) (
  input  logic              busCs,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output gpioStrobe_t       strobe
);

  logic wrCycle;
  logic rdCycle;

  assign wrCycle = busCs & busWe;
  assign rdCycle = busCs & ~busWe;

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_NONE;
    strobe.wrDir  = wrCycle && (busAddr == OFFS_DIR);
    strobe.wrOut  = wrCycle && (busAddr == OFFS_OUT);
    strobe.wrCtrl = wrCycle && (busAddr == OFFS_CTRL);
    strobe.wrMask = wrCycle && (busAddr == OFFS_MASK);
    if (rdCycle) begin
      unique case (busAddr)
        OFFS_DIR:  strobe.rdSel = RD_DIR;
        OFFS_OUT:  strobe.rdSel = RD_OUT;
        OFFS_IN:   strobe.rdSel = RD_IN;
        OFFS_CTRL: strobe.rdSel = RD_CTRL;
        OFFS_MASK: strobe.rdSel = RD_MASK;
        OFFS_STAT: strobe.rdSel = RD_STAT;
        default:   strobe.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int BUS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gpioStrobe_t          strobe,
  input  logic [NUM_LINES-1:0] laneWr,
  output logic [BUS_W-1:0]     busRdata,
  input  logic [NUM_LINES-1:0] padIn,
  output logic [NUM_LINES-1:0] padOe,
  output logic [NUM_LINES-1:0] padOut,
  output logic                 gpioIrq
);

  localparam int PAD_W = BUS_W - NUM_LINES;

  logic [NUM_LINES-1:0] dirQ;
  logic [NUM_LINES-1:0] outQ;
  logic [NUM_LINES-1:0] maskQ;
  logic                 mergeEnQ;
  logic [NUM_LINES-1:0] syncQ [SYNC_STAGES];
  logic [NUM_LINES-1:0] regWr;
  logic [NUM_LINES-1:0] rdReg;
  logic [NUM_LINES-1:0] rdLanes;
  logic [NUM_LINES-1:0] pinSync;
  logic [NUM_LINES-1:0] irqStatus;

  // Lane reversal: register bit n <-> upper bus lane (NUM_LINES-1-n)
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
    assign regWr[g]                 = laneWr[NUM_LINES-1-g];
    assign rdLanes[NUM_LINES-1-g]   = rdReg[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ     <= '0;
      outQ     <= '0;
      maskQ    <= '0;
      mergeEnQ <= 1'b0;
    end else begin
      if (strobe.wrDir)  dirQ     <= regWr;
      if (strobe.wrOut)  outQ     <= regWr;
      if (strobe.wrMask) maskQ    <= regWr;
      if (strobe.wrCtrl) mergeEnQ <= regWr[0];
    end
  end

  // Pad synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= padIn;
      else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  assign pinSync   = syncQ[SYNC_STAGES-1];
  assign irqStatus = pinSync & ~dirQ & {NUM_LINES{mergeEnQ}};
  assign gpioIrq   = |(irqStatus & maskQ);
  assign padOe     = dirQ;
  assign padOut    = outQ;

  always_comb begin
    unique case (strobe.rdSel)
      RD_DIR:  rdReg = dirQ;
      RD_OUT:  rdReg = outQ;
      RD_IN:   rdReg = pinSync;
      RD_CTRL: rdReg = {{(NUM_LINES-1){1'b0}}, mergeEnQ};
      RD_MASK: rdReg = maskQ;
      RD_STAT: rdReg = irqStatus;
      default: rdReg = '0;
    endcase
  end

  assign busRdata = {rdLanes, {PAD_W{1'b0}}};

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int BUS_W       = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busCs,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [BUS_W-1:0]     busWdata,
  output logic [BUS_W-1:0]     busRdata,
  input  logic [NUM_LINES-1:0] padIn,
  output logic [NUM_LINES-1:0] padOe,
  output logic [NUM_LINES-1:0] padOut,
  output logic                 gpioIrq
);

  gpioStrobe_t strobe;

  gpio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busCs   (busCs),
    .busWe   (busWe),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  gpio_datapath #(
    .NUM_LINES   (NUM_LINES),
    .BUS_W       (BUS_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .laneWr   (busWdata[BUS_W-1 -: NUM_LINES]),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOe    (padOe),
    .padOut   (padOut),
    .gpioIrq  (gpioIrq)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NUM_LINES = 8,
  parameter int BUS_W     = 16,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busCs,
  input logic                 busWe,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [BUS_W-1:0]     busWdata,
  input logic [BUS_W-1:0]     busRdata,
  input logic [NUM_LINES-1:0] padOe,
  input logic [NUM_LINES-1:0] padOut,
  input logic                 gpioIrq
);

  localparam int PAD_W = BUS_W - NUM_LINES;

  function automatic logic [NUM_LINES-1:0] flip(input logic [NUM_LINES-1:0] v);
    for (int i = 0; i < NUM_LINES; i++) flip[i] = v[NUM_LINES-1-i];
  endfunction

  logic dirWrite;
  logic outWrite;
  assign dirWrite = busCs && busWe && (busAddr == 8'h5C);
  assign outWrite = busCs && busWe && (busAddr == 8'h60);

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (padOe == '0 && padOut == '0 && !gpioIrq));

  // R2, R4
  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    dirWrite |=> padOe == flip($past(busWdata[BUS_W-1 -: NUM_LINES])));

  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !dirWrite |=> $stable(padOe));

  // R3, R4
  p_out_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    outWrite |=> padOut == flip($past(busWdata[BUS_W-1 -: NUM_LINES])));

  // R5
  p_low_lanes_r5: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[PAD_W-1:0] == '0);

  // R7
  p_irq_needs_input_r7: assert property (@(posedge clk) disable iff (!rstN)
    gpioIrq |-> (padOe != '1));

  // R10
  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(busCs && !busWe) |-> busRdata == '0);

endmodule

bind gpio_port gpio_port_chk #(
  .NUM_LINES (NUM_LINES),
  .BUS_W     (BUS_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busCs    (busCs),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .padOe    (padOe),
  .padOut   (padOut),
  .gpioIrq  (gpioIrq)
);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DIR  = 8'h5C;
  localparam logic [7:0] A_OUT  = 8'h60;
  localparam logic [7:0] A_IN   = 8'h64;
  localparam logic [7:0] A_CTRL = 8'h68;
  localparam logic [7:0] A_MASK = 8'h6C;
  localparam logic [7:0] A_STAT = 8'h70;

  typedef struct packed {
    logic        isWr;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [15:0] expRd;
    logic [7:0]  expOe;
    logic [7:0]  expOut;
  } vec_t;

  // R2 R3 R4 R5 R10 vectors, padIn held at zero
  localparam vec_t TBL [9] = '{
    '{1'b1, A_DIR, 16'h8000, 16'h0000, 8'h01, 8'h00},  // line 0 on bus bit 15
    '{1'b1, A_OUT, 16'h00FF, 16'h0000, 8'h01, 8'h00},  // low lanes ignored
    '{1'b1, A_OUT, 16'h0100, 16'h0000, 8'h01, 8'h80},  // line 7 on bus bit 8
    '{1'b1, A_DIR, 16'h0F00, 16'h0000, 8'hF0, 8'h80},
    '{1'b0, A_DIR, 16'h0000, 16'h0F00, 8'hF0, 8'h80},
    '{1'b0, A_OUT, 16'h0000, 16'h0100, 8'hF0, 8'h80},
    '{1'b1, A_OUT, 16'h30FF, 16'h0000, 8'hF0, 8'h0C},
    '{1'b0, A_OUT, 16'h0000, 16'h3000, 8'hF0, 8'h0C},
    '{1'b0, 8'h7E, 16'h0000, 16'h0000, 8'hF0, 8'h0C}   // unmapped offset
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busCs = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOe;
  logic [7:0]  padOut;
  logic        gpioIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  gpio_port u0 (
    .clk      (clk),
    .rstN     (rstN),
    .busCs    (busCs),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOe    (padOe),
    .padOut   (padOut),
    .gpioIrq  (gpioIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] toBus(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = v[i];
    return {r, 8'h00};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [15:0] d, input logic cs = 1'b1);
    @(negedge clk);
    busCs = cs; busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1;
    busCs = 1'b0; busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    busCs = 1'b1; busWe = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busCs = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 padOe", {8'h0, padOe}, 16'h0);
    check("R1 padOut", {8'h0, padOut}, 16'h0);
    check("R1 irq", {15'h0, gpioIrq}, 16'h0);
    busRead(A_CTRL, rd); check("R1 ctrl", rd, 16'h0);
    busRead(A_MASK, rd); check("R1 mask", rd, 16'h0);

    for (int i = 0; i < 9; i++) begin
      if (TBL[i].isWr) begin
        busWrite(TBL[i].addr, TBL[i].wdata);
      end else begin
        busRead(TBL[i].addr, rd);
        check($sformatf("R4 R5 R10 table rd %0d", i), rd, TBL[i].expRd);
      end
      check($sformatf("R2 table oe %0d", i), {8'h0, padOe}, {8'h0, TBL[i].expOe});
      check($sformatf("R3 table out %0d", i), {8'h0, padOut}, {8'h0, TBL[i].expOut});
    end

    // R10: write with chip select low
    busWrite(A_DIR, 16'hFF00, 1'b0);
    check("R10 cs low write", {8'h0, padOe}, 16'h00F0);
    @(negedge clk); busCs = 1'b0; busAddr = A_DIR; #1;
    check("R10 cs low read", busRdata, 16'h0);

    // R6 synchronizer timing, all lines inputs
    busWrite(A_DIR, 16'h0000);
    @(negedge clk); padIn = 8'h21;
    busRead(A_IN, rd); check("R6 after one edge", rd, 16'h0000);
    busRead(A_IN, rd); check("R6 after two edges", rd, toBus(8'h21));

    // R8 merge off: status zero even with pads high
    busWrite(A_MASK, toBus(8'hFF));
    busRead(A_STAT, rd); check("R8 merge off status", rd, 16'h0);
    check("R8 merge off irq", {15'h0, gpioIrq}, 16'h0);

    // R7 R8 merge on
    busWrite(A_CTRL, 16'h8000);
    busRead(A_CTRL, rd); check("R8 ctrl readback", rd, 16'h8000);
    busWrite(A_MASK, toBus(8'h02));
    busRead(A_STAT, rd); check("R7 status", rd, toBus(8'h21));
    check("R9 masked quiet line", {15'h0, gpioIrq}, 16'h0);
    busWrite(A_MASK, toBus(8'h20));
    check("R9 unmasked active line", {15'h0, gpioIrq}, 16'h1);

    // R7 status offset is read-only
    busWrite(A_STAT, 16'h0000);
    busRead(A_STAT, rd); check("R7 status write ignored", rd, toBus(8'h21));

    // R7 line turned to output leaves status
    busWrite(A_DIR, toBus(8'h20));
    busRead(A_STAT, rd); check("R7 output line excluded", rd, toBus(8'h01));
    check("R7 irq drops", {15'h0, gpioIrq}, 16'h0);

    // R8 merge cleared again
    busWrite(A_DIR, 16'h0000);
    check("R9 irq back", {15'h0, gpioIrq}, 16'h1);
    busWrite(A_CTRL, 16'h7FFF);
    busRead(A_STAT, rd); check("R8 merge cleared status", rd, 16'h0);
    check("R8 merge cleared irq", {15'h0, gpioIrq}, 16'h0);

    // R3 padOut independent of direction
    busWrite(A_OUT, toBus(8'hC3));
    check("R3 out while input", {8'h0, padOut}, 16'h00C3);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule